// File: doc/BRIEF.md
# Channel-Banked DMA Control Register Block

This block is the software-visible register file of a multi-channel DMA engine. Every channel owns a small bank of registers: a control word, a descriptor base address, a descriptor count, an interrupt enable and an interrupt status. All banks share one address window, and a channel-select register decides which bank that window currently reaches. Software writes the channel number once and then works on that channel's bank with ordinary reads and writes.

Beside the banks sit a few global registers: a read-only identification word, a global control word whose reset bit restarts every channel, a per-channel interrupt mask, and a small port-control bank that a separate port-select register indexes. Per-channel event inputs from the data-movement logic set status bits. A single level interrupt output combines the status of all channels. Reads take one clock: the read data register loads on the cycle the read strobe is high. Writes take effect on the clock edge that samples the write strobe.

Byte offsets: 0x08 identification, 0x10 global control, 0x18 channel select, 0x1C channel control, 0x20 descriptor base, 0x24 descriptor count, 0x28 channel status, 0x2C channel enable, 0x40 port select, 0x44 port control, 0xF4 global channel interrupt mask.

Top module: `chbank_regs`

## Requirements
- R1: A read of 0x08 returns the channel count in bits 31:20, the port count in bits 19:16 and the revision parameter in bits 4:0, with all other bits 0. Writes to it have no effect.
- R2: The value written to 0x18 selects the bank reached through 0x1C to 0x2C. The select field is 5 bits wide by default and reads back as written. Base (32 bits) and count (16 bits, upper bits dropped) of one channel are unaffected by writes made while another channel is selected.
- R3: The channel control word keeps bit 0 (channel on), bit 8 (transmit direction) and bits 17:16 (arbitration weight). All other bits read 0, except bit 1.
- R4: Writing 1 to control bit 1 starts a channel reset. Bit 1 reads 1 on exactly the next 4 reads issued back to back after that write, and 0 from then on. When the reset completes, the on bit and the status are cleared, while direction, weight, base and count are kept.
- R5: The channel status at 0x28 holds event bits in positions 6:1, where event input k sets bit k+1. Bit 3 is descriptor-complete. Writing 1 to a bit clears it, and writing 0x7E clears all of them.
- R6: An event arriving in the same cycle as a write-1-to-clear of the same bit leaves that bit set. Other bits named in the write are still cleared.
- R7: The channel enable at 0x2C keeps bits 6:1 only. All other bits read 0.
- R8: The interrupt output is high exactly when, for some channel n, bit n of 0xF4 is set and the channel's status ANDed with its enable is non-zero. Writing 0 to 0xF4 drops it. The register at 0xF4 reads back as written.
- R9: While the select value is 20 or more, writes to 0x1C-0x2C change no channel and reads of them return 0.
- R10: Writing 1 to bit 0 of 0x10 starts a channel reset on every channel at once. Bit 0 of 0x10 reads 1 while any channel reset is in progress.
- R11: 0x40 selects one of 4 port control words (3-bit field). Word 0x44 reads and writes the selected port. A port select of 4 or more drops writes to 0x44 and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 8 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe; data appears on rdata_o the next cycle |
| rdata_o | output | 32 | Registered read data |
| ev_i | input | 120 | Event pulses, 6 per channel; channel c uses bits 6c+5:6c |
| irq_o | output | 1 | Combined channel interrupt |

## Verification
The assertions assume that write and read strobes are never both high in one cycle. They also assume that event inputs are single-cycle pulses that may coincide with any register access, and that the address is stable while a strobe is high. The directed stimulus changes every input only on the falling clock edge and raises at most one strobe at a time. It lines up an event pulse with a status clear on purpose, to reach the set-wins case. It also runs reads back to back right after a reset request, so that each cycle of the reset window is sampled once.

// File: rtl/chbank_pkg.sv
package chbank_pkg;
   // byte offsets of the register map
   localparam int OFF_ID    = 'h08;
   localparam int OFF_GCTL  = 'h10;
   localparam int OFF_CSEL  = 'h18;
   localparam int OFF_CCTL  = 'h1C;
   localparam int OFF_CBASE = 'h20;
   localparam int OFF_CCNT  = 'h24;
   localparam int OFF_CST   = 'h28;
   localparam int OFF_CEN   = 'h2C;
   localparam int OFF_PSEL  = 'h40;
   localparam int OFF_PCTL  = 'h44;
   localparam int OFF_GEN   = 'hF4;

   // channel control field positions
   localparam int CTL_ON  = 0;
   localparam int CTL_RST = 1;
   localparam int CTL_TX  = 8;
   localparam int CTL_WT  = 16;
endpackage

// File: rtl/chbank_chan.sv
module chbank_chan
   import chbank_pkg::*;
#(
   parameter int EVW     = 6,
   parameter int CNTW    = 16,
   parameter int RST_CYC = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_ctrl,
   input  logic            wr_base,
   input  logic            wr_cnt,
   input  logic            wr_st,
   input  logic            wr_en,
   input  logic [31:0]     wdata,
   input  logic            grst,
   input  logic [EVW-1:0]  ev,
   output logic [31:0]     ctrl_rd,
   output logic [31:0]     base_q,
   output logic [CNTW-1:0] cnt_q,
   output logic [EVW-1:0]  st_q,
   output logic [EVW-1:0]  en_q,
   output logic            busy_q,
   output logic            pend
);
   localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC + 1) : 1;

   logic       on_q, tx_q;
   logic [1:0] wt_q;
   logic       start, done;
   logic [EVW-1:0] clr;

   assign start = (wr_ctrl && wdata[CTL_RST]) || grst;
   assign clr   = wr_st ? wdata[EVW:1] : '0;

   generate
      if (RST_CYC > 1) begin : g_cnt
         logic [CW-1:0] rc_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)                      rc_q <= '0;
            else if (start)                   rc_q <= CW'(RST_CYC);
            else if (busy_q && rc_q != CW'(1)) rc_q <= rc_q - CW'(1);
         end
         assign done = busy_q && (rc_q == CW'(1));

         // R4: a started reset lasts more than one cycle
         a_r4_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(busy_q) |=> busy_q);
      end else begin : g_single
         assign done = busy_q;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         on_q   <= 1'b0;
         tx_q   <= 1'b0;
         wt_q   <= 2'b00;
         base_q <= '0;
         cnt_q  <= '0;
         st_q   <= '0;
         en_q   <= '0;
         busy_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            on_q <= wdata[CTL_ON];
            tx_q <= wdata[CTL_TX];
            wt_q <= wdata[CTL_WT+1:CTL_WT];
         end
         if (wr_base) base_q <= wdata;
         if (wr_cnt)  cnt_q  <= wdata[CNTW-1:0];
         if (wr_en)   en_q   <= wdata[EVW:1];
         st_q <= (st_q & ~clr) | ev;
         if (start)     busy_q <= 1'b1;
         else if (done) begin
            busy_q <= 1'b0;
            on_q   <= 1'b0;
            st_q   <= '0;
         end
      end
   end

   assign ctrl_rd = {14'b0, wt_q, 7'b0, tx_q, 6'b0, busy_q, on_q};
   assign pend    = |(st_q & en_q);

   // R4: completion leaves the channel off with empty status
   a_r4_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_q) |-> (!on_q && st_q == '0));

   // R6: an event is never lost to a simultaneous clear
   a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev != '0 && !done) |=> ((st_q & $past(ev)) == $past(ev)));

   // R5: a clear without competing events empties the named bits
   a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_st && ev == '0 && !done) |=> ((st_q & $past(wdata[EVW:1])) == '0));
endmodule

// File: rtl/chbank_portbank.sv
module chbank_portbank #(
   parameter int NPORT = 4,
   parameter int PSW   = 3
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           wr,
   input  logic [PSW-1:0] idx,
   input  logic [31:0]    wdata,
   output logic [31:0]    rdata
);
   logic [31:0] pw [NPORT];

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         always_ff @(posedge clk_i) begin
            if (!rst_ni)                        pw[p] <= '0;
            else if (wr && idx == PSW'(p))      pw[p] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NPORT; p++)
         if (idx == PSW'(p)) rdata = pw[p];
   end

   // R11: an out-of-range port index reads as zero
   a_r11_oor_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(idx) >= NPORT) |-> (rdata == '0));
endmodule

// File: rtl/chbank_regs.sv
module chbank_regs
   import chbank_pkg::*;
#(
   parameter int         NCH     = 20,
   parameter int         NPORT   = 4,
   parameter int         EVW     = 6,
   parameter int         CNTW    = 16,
   parameter int         RST_CYC = 4,
   parameter int         AW      = 8,
   parameter logic [4:0] REV     = 5'h03
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [AW-1:0]      addr_i,
   input  logic [31:0]        wdata_i,
   input  logic               wr_i,
   input  logic               rd_i,
   output logic [31:0]        rdata_o,
   input  logic [NCH*EVW-1:0] ev_i,
   output logic               irq_o
);
   localparam int SELW = $clog2(NCH + 1);
   localparam int PSW  = $clog2(NPORT + 1);
   localparam logic [31:0] ID_WORD = {12'(NCH), 4'(NPORT), 11'b0, REV};

   generate
      if (NCH < 1 || NCH > 32)    begin : g_bad_nch  $error("NCH must be 1..32");   end
      if (NPORT < 1 || NPORT > 15) begin : g_bad_np  $error("NPORT must be 1..15"); end
      if (EVW < 1 || EVW > 30)    begin : g_bad_evw  $error("EVW must be 1..30");   end
      if (CNTW < 1 || CNTW > 32)  begin : g_bad_cntw $error("CNTW must be 1..32");  end
      if (RST_CYC < 1)            begin : g_bad_rst  $error("RST_CYC must be >= 1"); end
      if (AW < 8)                 begin : g_bad_aw   $error("AW must be >= 8");     end
   endgenerate

   logic [SELW-1:0] sel_q;
   logic [PSW-1:0]  psel_q;
   logic [NCH-1:0]  gen_q;
   logic [31:0]     rdata_q, rv, bank_rv, port_rv;
   logic            sel_ok, is_bank, grst;
   logic            w_ctl, w_base, w_cnt, w_st, w_en;

   logic [31:0]     ctrl_w [NCH];
   logic [31:0]     base_w [NCH];
   logic [CNTW-1:0] cnt_w  [NCH];
   logic [EVW-1:0]  st_w   [NCH];
   logic [EVW-1:0]  en_w   [NCH];
   logic [NCH-1:0]  busy_w, pend_w;

   assign sel_ok  = int'(sel_q) < NCH;
   assign is_bank = addr_i == AW'(OFF_CCTL) || addr_i == AW'(OFF_CBASE) ||
                    addr_i == AW'(OFF_CCNT) || addr_i == AW'(OFF_CST)   ||
                    addr_i == AW'(OFF_CEN);
   assign grst    = wr_i && addr_i == AW'(OFF_GCTL) && wdata_i[0];
   assign w_ctl   = wr_i && sel_ok && addr_i == AW'(OFF_CCTL);
   assign w_base  = wr_i && sel_ok && addr_i == AW'(OFF_CBASE);
   assign w_cnt   = wr_i && sel_ok && addr_i == AW'(OFF_CCNT);
   assign w_st    = wr_i && sel_ok && addr_i == AW'(OFF_CST);
   assign w_en    = wr_i && sel_ok && addr_i == AW'(OFF_CEN);

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic hit;
         assign hit = sel_q == SELW'(c);
         chbank_chan #(.EVW(EVW), .CNTW(CNTW), .RST_CYC(RST_CYC)) u_chan (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_ctrl (w_ctl  && hit),
            .wr_base (w_base && hit),
            .wr_cnt  (w_cnt  && hit),
            .wr_st   (w_st   && hit),
            .wr_en   (w_en   && hit),
            .wdata   (wdata_i),
            .grst    (grst),
            .ev      (ev_i[c*EVW +: EVW]),
            .ctrl_rd (ctrl_w[c]),
            .base_q  (base_w[c]),
            .cnt_q   (cnt_w[c]),
            .st_q    (st_w[c]),
            .en_q    (en_w[c]),
            .busy_q  (busy_w[c]),
            .pend    (pend_w[c])
         );
      end
   endgenerate

   chbank_portbank #(.NPORT(NPORT), .PSW(PSW)) u_ports (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr     (wr_i && addr_i == AW'(OFF_PCTL)),
      .idx    (psel_q),
      .wdata  (wdata_i),
      .rdata  (port_rv)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sel_q  <= '0;
         psel_q <= '0;
         gen_q  <= '0;
      end else if (wr_i) begin
         if (addr_i == AW'(OFF_CSEL)) sel_q  <= wdata_i[SELW-1:0];
         if (addr_i == AW'(OFF_PSEL)) psel_q <= wdata_i[PSW-1:0];
         if (addr_i == AW'(OFF_GEN))  gen_q  <= wdata_i[NCH-1:0];
      end
   end

   always_comb begin
      bank_rv = '0;
      for (int c = 0; c < NCH; c++) begin
         if (sel_q == SELW'(c)) begin
            if (addr_i == AW'(OFF_CCTL))  bank_rv = ctrl_w[c];
            if (addr_i == AW'(OFF_CBASE)) bank_rv = base_w[c];
            if (addr_i == AW'(OFF_CCNT))  bank_rv = 32'(cnt_w[c]);
            if (addr_i == AW'(OFF_CST))   bank_rv = 32'({st_w[c], 1'b0});
            if (addr_i == AW'(OFF_CEN))   bank_rv = 32'({en_w[c], 1'b0});
         end
      end
   end

   always_comb begin
      rv = '0;
      if (is_bank)                        rv = bank_rv;
      else if (addr_i == AW'(OFF_ID))     rv = ID_WORD;
      else if (addr_i == AW'(OFF_GCTL))   rv = {31'b0, |busy_w};
      else if (addr_i == AW'(OFF_CSEL))   rv = 32'(sel_q);
      else if (addr_i == AW'(OFF_PSEL))   rv = 32'(psel_q);
      else if (addr_i == AW'(OFF_PCTL))   rv = port_rv;
      else if (addr_i == AW'(OFF_GEN))    rv = 32'(gen_q);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)   rdata_q <= '0;
      else if (rd_i) rdata_q <= rv;
   end

   assign rdata_o = rdata_q;
   assign irq_o   = |(gen_q & pend_w);

   // R9: banked reads through an invalid select return zero
   a_r9_oor_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && is_bank && !sel_ok) |=> (rdata_o == '0));

   // R8: no interrupt unless some channel is globally enabled
   a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (gen_q != '0));

   // R2: the channel select changes only on its own write
   a_r2_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == AW'(OFF_CSEL)) |=> $stable(sel_q));
endmodule

// File: tb/chbank_regs_tb.sv
`timescale 1ns/1ps
module chbank_regs_tb;
   localparam int NCH = 20, NPORT = 4, EVW = 6;
   localparam logic [4:0] REV = 5'h03;

   logic clk = 0, rst_n = 0;
   logic [7:0] addr = 0;
   logic [31:0] wdata = 0;
   logic wr = 0, rd = 0;
   logic [31:0] rdata;
   logic [NCH*EVW-1:0] ev = '0;
   logic irq;
   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   chbank_regs #(.NCH(NCH), .NPORT(NPORT), .EVW(EVW), .REV(REV)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
      .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .ev_i(ev), .irq_o(irq));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wreg(logic [7:0] a, logic [31:0] d);
      addr = a; wdata = d; wr = 1;
      @(negedge clk);
      wr = 0;
   endtask

   task automatic rreg(logic [7:0] a, output logic [31:0] d);
      addr = a; rd = 1;
      @(negedge clk);
      rd = 0; d = rdata;
   endtask

   task automatic pulse(int ch, logic [EVW-1:0] v);
      ev[ch*EVW +: EVW] = v;
      @(negedge clk);
      ev = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R8 irq after reset", 32'(irq), 0);
      rreg(8'hF4, d); chk("R8 mask after reset", d, 0);
      rreg(8'h1C, d); chk("R3 ctrl after reset", d, 0);
   endtask

   task automatic t_id();
      logic [31:0] d;
      rreg(8'h08, d); chk("R1 id word", d, {12'd20, 4'd4, 11'd0, REV});
      wreg(8'h08, 32'h0);
      rreg(8'h08, d); chk("R1 id after write", d, {12'd20, 4'd4, 11'd0, REV});
   endtask

   task automatic t_bank();
      logic [31:0] d;
      wreg(8'h18, 2);  wreg(8'h20, 32'hA000_1000); wreg(8'h24, 32'hFFFF_0040);
      wreg(8'h18, 19); wreg(8'h20, 32'h5555_AAA0); wreg(8'h24, 32'h0000_1234);
      rreg(8'h18, d); chk("R2 select readback", d, 19);
      rreg(8'h20, d); chk("R2 base ch19", d, 32'h5555_AAA0);
      wreg(8'h18, 2);
      rreg(8'h20, d); chk("R2 base ch2", d, 32'hA000_1000);
      rreg(8'h24, d); chk("R2 count ch2 width", d, 32'h0040);
   endtask

   task automatic t_ctrl();
      logic [31:0] d;
      wreg(8'h18, 2); wreg(8'h1C, 32'hFFFF_FFFD);
      rreg(8'h1C, d); chk("R3 ctrl fields", d, 32'h0003_0101);
   endtask

   task automatic t_chrst();
      logic [31:0] d;
      int busy_n = 0;
      wreg(8'h18, 2);
      pulse(2, 6'b000100);
      wreg(8'h1C, 32'h0001_0103);
      for (int i = 0; i < 6; i++) begin
         rreg(8'h1C, d);
         if (d[1]) busy_n++;
         if (i == 0) chk("R4 ctrl during reset", d, 32'h0001_0103);
      end
      chk("R4 reset length in reads", busy_n, 4);
      rreg(8'h1C, d); chk("R4 ctrl after reset", d, 32'h0001_0100);
      rreg(8'h28, d); chk("R4 status cleared", d, 0);
      rreg(8'h20, d); chk("R4 base kept", d, 32'hA000_1000);
      rreg(8'h24, d); chk("R4 count kept", d, 32'h0040);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wreg(8'h18, 7);
      pulse(7, 6'b101101);
      rreg(8'h28, d); chk("R5 events to status", d, 32'h5A);
      wreg(8'h28, 32'h08);
      rreg(8'h28, d); chk("R5 single clear", d, 32'h52);
      wreg(8'h28, 32'h7E);
      rreg(8'h28, d); chk("R5 clear all", d, 0);
   endtask

   task automatic t_setwins();
      logic [31:0] d;
      wreg(8'h18, 7);
      pulse(7, 6'b000001);
      ev[7*EVW +: EVW] = 6'b000100;
      wreg(8'h28, 32'h0A);
      ev = '0;
      rreg(8'h28, d); chk("R6 set wins over clear", d, 32'h08);
   endtask

   task automatic t_en();
      logic [31:0] d;
      wreg(8'h18, 7); wreg(8'h2C, 32'hFFFF_FFFF);
      rreg(8'h2C, d); chk("R7 enable mask", d, 32'h7E);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wreg(8'h18, 7); wreg(8'h2C, 32'h08);
      wreg(8'hF4, 32'h80);
      chk("R8 irq raised", 32'(irq), 1);
      rreg(8'hF4, d); chk("R8 mask readback", d, 32'h80);
      wreg(8'hF4, 0);
      chk("R8 irq off by global mask", 32'(irq), 0);
      wreg(8'hF4, 32'h40);
      chk("R8 other channel bit", 32'(irq), 0);
      wreg(8'hF4, 32'h80); wreg(8'h2C, 32'h04);
      chk("R8 channel enable gates", 32'(irq), 0);
      wreg(8'h2C, 32'h08);
      chk("R8 irq back", 32'(irq), 1);
      wreg(8'h28, 32'h7E);
      chk("R8 irq after clear", 32'(irq), 0);
   endtask

   task automatic t_oor();
      logic [31:0] d;
      wreg(8'h18, 20);
      rreg(8'h18, d); chk("R9 select holds 20", d, 20);
      wreg(8'h20, 32'hDEAD_BEEF); wreg(8'h1C, 32'h1);
      rreg(8'h20, d); chk("R9 base reads 0", d, 0);
      rreg(8'h1C, d); chk("R9 ctrl reads 0", d, 0);
      wreg(8'h18, 19);
      rreg(8'h20, d); chk("R9 ch19 base untouched", d, 32'h5555_AAA0);
      rreg(8'h1C, d); chk("R9 ch19 ctrl untouched", d, 0);
   endtask

   task automatic t_grst();
      logic [31:0] d;
      int polls = 0;
      wreg(8'h18, 19); wreg(8'h1C, 32'h1);
      wreg(8'h18, 2);  wreg(8'h1C, 32'h0001_0101);
      wreg(8'h10, 32'h1);
      rreg(8'h10, d); chk("R10 global busy", d, 1);
      do begin rreg(8'h10, d); polls++; end while (d[0] && polls < 20);
      chk("R10 global reset finished", d, 0);
      rreg(8'h1C, d); chk("R10 ch2 off", d, 32'h0001_0100);
      wreg(8'h18, 19);
      rreg(8'h1C, d); chk("R10 ch19 off", d, 0);
      rreg(8'h20, d); chk("R10 ch19 base kept", d, 32'h5555_AAA0);
   endtask

   task automatic t_port();
      logic [31:0] d;
      wreg(8'h40, 1); wreg(8'h44, 32'h11);
      wreg(8'h40, 3); wreg(8'h44, 32'h33);
      rreg(8'h44, d); chk("R11 port 3", d, 32'h33);
      wreg(8'h40, 4); wreg(8'h44, 32'hFF);
      rreg(8'h44, d); chk("R11 out of range reads 0", d, 0);
      wreg(8'h40, 1);
      rreg(8'h44, d); chk("R11 port 1 kept", d, 32'h11);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset(); t_id(); t_bank(); t_ctrl(); t_chrst();
      t_w1c(); t_setwins(); t_en(); t_irq(); t_oor(); t_grst(); t_port();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule